// File: doc/BRIEF.md
# Paired-Command DRAM Sequencer

This block sits between a simple request port and a four-bank, double-data-rate, fast-cycle DRAM. That memory accepts every access as two commands on consecutive clocks. The first is an activate, either for a read or for a write, and it carries the bank and the upper (row) address. The second command follows in the very next cycle. It is either a latch of the lower (column) address, or a control command that turns the pair into a mode-register write or an auto-refresh. The sequencer turns single-beat user requests into these pairs. It spaces pairs by the random cycle time and inserts auto-refresh pairs on a fixed interval. It also enters and leaves power-down on request.

After reset the block holds the command bus at deselect for a fixed start-up period. It then programs the regular mode register and the extended mode register with parameter values, and only after that does it open the request port. The user side is a valid/ready handshake. A request is taken on a clock edge where both are high, and its first command appears on the pins in the cycle after that edge. Data movement, strobes and pad timing belong to other blocks.

Top module: `pair_cmd_sequencer`

## Requirements
- R1: While reset is held, and in the cycle after it, the pins show deselect, `dram_pd_n` is high, and both `req_ready` and `init_done` are low. `req_ready` never rises while `init_done` is low.
- R2: No command other than deselect appears during the first `INIT_CYCLES` clocks after reset. Two mode-register writes then follow: first bank code 00 with `MR_VALUE`, then bank code 01 with `EMR_VALUE`, each carried on both commands of its pair. `init_done` rises only after both pairs.
- R3: A first command has `dram_cs_n`=0, with `dram_fn`=1 for read-activate and 0 for write-activate. The cycle directly after it always carries the second command. That is either the lower-address latch (`dram_cs_n`=1, `dram_fn`=1) or the mode-set/refresh code (`dram_cs_n`=0, `dram_fn`=0).
- R4: A request with `req_op`=00 gives read-activate with `req_bank` and `req_row`, then a lower-address latch with `req_bank` and `req_col` in the low address bits, with the upper address bits zero.
- R5: A request with `req_op`=01 gives the same pair, but the first command is write-activate.
- R6: A request with `req_op[1]`=1 gives read-activate, then mode-set. Both commands carry `req_bank` as the register select and `req_row` as the value.
- R7: First commands of any kind are at least `RC_CYCLES` clocks apart.
- R8: `req_ready` is low from an accepted request until the cycle gap has expired. A request that is held waiting is issued exactly `RC_CYCLES` clocks after the previous pair.
- R9: An auto-refresh is a write-activate followed by the mode-set/refresh code, both with bank and address zero. A due refresh is served ahead of any waiting request. Consecutive refreshes are at least `REFI_CYCLES-RC_CYCLES-PDX_CYCLES` and at most `REFI_CYCLES+RC_CYCLES+PDX_CYCLES` clocks apart.
- R10: `dram_pd_n` falls only when `pd_req` is high, the cycle gap has expired and no refresh is due. While it is low, the pins show deselect and `req_ready` is low.
- R11: `dram_pd_n` rises when `pd_req` falls or a refresh falls due. No first command follows within `PDX_CYCLES` clocks of the rise. Refreshes keep coming while `pd_req` stays high.
- R12: Every cycle that holds neither command of a pair shows deselect (`dram_cs_n`=1, `dram_fn`=0) with bank and address zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken on this edge if valid |
| req_op | input | 2 | 00 read, 01 write, 1x mode-register write |
| req_bank | input | BANK_W | Bank, or mode register select |
| req_row | input | ROW_W | Upper address, or mode value |
| req_col | input | COL_W | Lower address |
| pd_req | input | 1 | Level request for power-down |
| init_done | output | 1 | Start-up programming finished |
| dram_cs_n | output | 1 | Chip select, active low |
| dram_fn | output | 1 | Function select |
| dram_ba | output | BANK_W | Bank address |
| dram_addr | output | ROW_W | Address bus |
| dram_pd_n | output | 1 | Power-down pin, low to enter |

## Verification
The assertions watch the command bus on every cycle. They check the pairing of second commands, the minimum spacing between first commands, the start-up silence, the quiet bus during power-down, the wake-up gap, and the zeroed deselect. The address and bank contents of each pair, the order of the two mode-register writes, the exact back-to-back spacing of waiting requests, and the refresh interval bounds, including refreshes that pull the block out of power-down, are shown only by the bench's scenarios. The bench decodes the pins by slot and compares them with the request it handed over.

// File: rtl/seq_pkg.sv
`timescale 1ns/1ps
// Shared types for the paired-command sequencer.
// Assumes: command codes are abstract here; pin encodings live in seq_pin_driver.
package seq_pkg;
    typedef enum logic [2:0] {
        C_DESEL,   // idle bus
        C_RDA,     // read-activate, first slot
        C_WRA,     // write-activate, first slot
        C_LAL,     // lower-address latch, second slot
        C_MRS,     // mode-set, second slot after read-activate
        C_REF      // auto-refresh, second slot after write-activate
    } cmd_t;

    typedef enum logic [1:0] {
        S_BOOT,    // start-up wait and mode programming
        S_IDLE,    // ready for a new pair
        S_SECOND,  // second command of a pair is being registered
        S_PDOWN    // power-down pin held low
    } state_t;
endpackage

// File: rtl/seq_gap_timer.sv
`timescale 1ns/1ps
// Down-counter that marks when the minimum spacing after an event has elapsed.
// Assumes: load has priority over counting; reset value sets the start-up wait.
module seq_gap_timer #(
    parameter int unsigned W         = 8,
    parameter int unsigned RESET_VAL = 199
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    // Count down to zero, reload on request.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= W'(RESET_VAL);
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/seq_refresh_timer.sv
`timescale 1ns/1ps
// Free-running refresh interval counter with a sticky pending flag.
// Assumes: en stays high once start-up is done; clear marks the refresh issue.
module seq_refresh_timer #(
    parameter int unsigned PERIOD = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clear,
    output logic pending
);
    localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [CW-1:0] cnt_q;
    logic          pend_q;
    logic          wrap;

    assign wrap = en && (cnt_q == CW'(PERIOD - 1));

    // Interval counter, restarts on each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt_q <= '0;
        else if (wrap)     cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end

    // Pending flag: a new wrap wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= 1'b0;
        else if (wrap)   pend_q <= 1'b1;
        else if (clear)  pend_q <= 1'b0;
    end

    assign pending = pend_q;
endmodule

// File: rtl/seq_pin_driver.sv
`timescale 1ns/1ps
// Registers the next command onto the memory pins with its select encoding.
// Assumes: the caller zeroes bank and address for deselect.
module seq_pin_driver
    import seq_pkg::*;
#(
    parameter int unsigned BANK_W = 2,
    parameter int unsigned ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_t              cmd_i,
    input  logic [BANK_W-1:0] ba_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              cs_n_o,
    output logic              fn_o,
    output logic [BANK_W-1:0] ba_o,
    output logic [ADDR_W-1:0] addr_o
);
    logic cs_n_d, fn_d;

    // Map the abstract command onto the two select pins.
    always_comb begin
        unique case (cmd_i)
            C_RDA:   begin cs_n_d = 1'b0; fn_d = 1'b1; end
            C_WRA:   begin cs_n_d = 1'b0; fn_d = 1'b0; end
            C_LAL:   begin cs_n_d = 1'b1; fn_d = 1'b1; end
            C_MRS:   begin cs_n_d = 1'b0; fn_d = 1'b0; end
            C_REF:   begin cs_n_d = 1'b0; fn_d = 1'b0; end
            default: begin cs_n_d = 1'b1; fn_d = 1'b0; end
        endcase
    end

    // Pin register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n_o <= 1'b1;
            fn_o   <= 1'b0;
            ba_o   <= '0;
            addr_o <= '0;
        end else begin
            cs_n_o <= cs_n_d;
            fn_o   <= fn_d;
            ba_o   <= ba_i;
            addr_o <= addr_i;
        end
    end
endmodule

// File: rtl/pair_cmd_sequencer.sv
`timescale 1ns/1ps
// Front end for a paired-command DRAM: start-up mode programming, user pairs,
// distributed auto-refresh and power-down control.
// Assumes: req_* held stable while req_valid is high and req_ready low;
// pd_req is a level; all commands leave through one register stage.
module pair_cmd_sequencer
    import seq_pkg::*;
#(
    parameter int unsigned BANK_W      = 2,
    parameter int unsigned ROW_W       = 15,
    parameter int unsigned COL_W       = 7,
    parameter int unsigned INIT_CYCLES = 200,
    parameter int unsigned RC_CYCLES   = 5,
    parameter int unsigned REFI_CYCLES = 1560,
    parameter int unsigned PDX_CYCLES  = 2,
    parameter logic [ROW_W-1:0] MR_VALUE  = 15'h0032,
    parameter logic [ROW_W-1:0] EMR_VALUE = 15'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              pd_req,
    output logic              init_done,
    output logic              dram_cs_n,
    output logic              dram_fn,
    output logic [BANK_W-1:0] dram_ba,
    output logic [ROW_W-1:0]  dram_addr,
    output logic              dram_pd_n
);
    localparam int unsigned GAP_MAX0 = (RC_CYCLES > PDX_CYCLES) ? RC_CYCLES : PDX_CYCLES;
    localparam int unsigned GAP_MAX  = (INIT_CYCLES > GAP_MAX0) ? INIT_CYCLES : GAP_MAX0;
    localparam int unsigned GAP_W    = $clog2(GAP_MAX + 1);
    localparam logic [GAP_W-1:0] RC_LOAD  = GAP_W'(RC_CYCLES - 1);
    localparam logic [GAP_W-1:0] PDX_LOAD = GAP_W'((PDX_CYCLES > 0) ? PDX_CYCLES - 1 : 0);

    state_t             state_q;
    logic [1:0]         boot_step_q;
    logic               init_done_q;
    logic               pd_n_q;
    cmd_t               sec_cmd_q;
    logic [BANK_W-1:0]  sec_ba_q;
    logic [ROW_W-1:0]   sec_addr_q;

    logic               gap_ok, ref_pending;
    logic               boot_done, boot_go, start_ref, start_user, enter_pd, exit_pd;
    logic               gap_load;
    logic [GAP_W-1:0]   gap_val;
    cmd_t               cmd_d;
    logic [BANK_W-1:0]  ba_d;
    logic [ROW_W-1:0]   addr_d;
    logic [BANK_W-1:0]  mode_ba;
    logic [ROW_W-1:0]   mode_val;

    // Decide which event may start this cycle.
    always_comb begin
        boot_done  = (boot_step_q == 2'd2);
        boot_go    = (state_q == S_BOOT) && gap_ok;
        start_ref  = (state_q == S_IDLE) && gap_ok && init_done_q && ref_pending;
        enter_pd   = (state_q == S_IDLE) && gap_ok && init_done_q && !ref_pending && pd_req;
        req_ready  = (state_q == S_IDLE) && gap_ok && init_done_q && !ref_pending && !pd_req;
        start_user = req_valid && req_ready;
        exit_pd    = (state_q == S_PDOWN) && (!pd_req || ref_pending);
        mode_ba    = boot_step_q[0] ? BANK_W'(1) : '0;
        mode_val   = boot_step_q[0] ? EMR_VALUE : MR_VALUE;
    end

    // Choose the command for the pin register and the next gap to wait.
    always_comb begin
        cmd_d    = C_DESEL;
        ba_d     = '0;
        addr_d   = '0;
        gap_load = 1'b0;
        gap_val  = RC_LOAD;
        if (state_q == S_SECOND) begin
            cmd_d  = sec_cmd_q;
            ba_d   = sec_ba_q;
            addr_d = sec_addr_q;
        end else if (boot_go) begin
            cmd_d    = C_RDA;
            ba_d     = mode_ba;
            addr_d   = mode_val;
            gap_load = 1'b1;
        end else if (start_ref) begin
            cmd_d    = C_WRA;
            gap_load = 1'b1;
        end else if (start_user) begin
            cmd_d    = (req_op == 2'b01) ? C_WRA : C_RDA;
            ba_d     = req_bank;
            addr_d   = req_row;
            gap_load = 1'b1;
        end else if (exit_pd) begin
            gap_load = 1'b1;
            gap_val  = PDX_LOAD;
        end
    end

    // Sequencer state, start-up progress and the held second command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= S_BOOT;
            boot_step_q <= 2'd0;
            init_done_q <= 1'b0;
            pd_n_q      <= 1'b1;
            sec_cmd_q   <= C_DESEL;
            sec_ba_q    <= '0;
            sec_addr_q  <= '0;
        end else begin
            unique case (state_q)
                S_BOOT: if (boot_go) begin
                    state_q     <= S_SECOND;
                    boot_step_q <= boot_step_q + 2'd1;
                    sec_cmd_q   <= C_MRS;
                    sec_ba_q    <= mode_ba;
                    sec_addr_q  <= mode_val;
                end
                S_IDLE: if (start_ref) begin
                    state_q    <= S_SECOND;
                    sec_cmd_q  <= C_REF;
                    sec_ba_q   <= '0;
                    sec_addr_q <= '0;
                end else if (enter_pd) begin
                    state_q <= S_PDOWN;
                    pd_n_q  <= 1'b0;
                end else if (start_user) begin
                    state_q    <= S_SECOND;
                    sec_cmd_q  <= req_op[1] ? C_MRS : C_LAL;
                    sec_ba_q   <= req_bank;
                    sec_addr_q <= req_op[1] ? req_row : ROW_W'(req_col);
                end
                S_SECOND: begin
                    state_q <= boot_done ? S_IDLE : S_BOOT;
                    if (boot_done) init_done_q <= 1'b1;
                end
                S_PDOWN: if (exit_pd) begin
                    state_q <= S_IDLE;
                    pd_n_q  <= 1'b1;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    seq_gap_timer #(.W(GAP_W), .RESET_VAL(INIT_CYCLES - 1)) u_gap (
        .clk(clk), .rst_n(rst_n), .load(gap_load), .load_val(gap_val), .expired(gap_ok)
    );

    seq_refresh_timer #(.PERIOD(REFI_CYCLES)) u_refi (
        .clk(clk), .rst_n(rst_n), .en(init_done_q), .clear(start_ref), .pending(ref_pending)
    );

    seq_pin_driver #(.BANK_W(BANK_W), .ADDR_W(ROW_W)) u_pins (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_d), .ba_i(ba_d), .addr_i(addr_d),
        .cs_n_o(dram_cs_n), .fn_o(dram_fn), .ba_o(dram_ba), .addr_o(dram_addr)
    );

    assign init_done = init_done_q;
    assign dram_pd_n = pd_n_q;
endmodule

// File: rtl/pair_cmd_sequencer_chk.sv
`timescale 1ns/1ps
// Protocol checker for pair_cmd_sequencer, watching only its ports.
// Assumes: a first command is any cs_n low cycle not already in a second slot.
module pair_cmd_sequencer_chk #(
    parameter int unsigned BANK_W      = 2,
    parameter int unsigned ROW_W       = 15,
    parameter int unsigned INIT_CYCLES = 200,
    parameter int unsigned RC_CYCLES   = 5,
    parameter int unsigned PDX_CYCLES  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              init_done,
    input logic              dram_cs_n,
    input logic              dram_fn,
    input logic [BANK_W-1:0] dram_ba,
    input logic [ROW_W-1:0]  dram_addr,
    input logic              dram_pd_n
);
    localparam int unsigned CW = $clog2(INIT_CYCLES + RC_CYCLES + PDX_CYCLES + 2) + 1;

    logic          sec_q;
    logic [CW-1:0] since_first, since_wake, boot_cnt;
    logic          first_now;

    assign first_now = !sec_q && !dram_cs_n;

    // Slot tracker and saturating distance counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q       <= 1'b0;
            since_first <= '1;
            since_wake  <= '1;
            boot_cnt    <= '0;
        end else begin
            sec_q       <= first_now;
            since_first <= first_now ? CW'(1) : ((since_first != '1) ? since_first + 1'b1 : since_first);
            since_wake  <= !dram_pd_n ? '0 : ((since_wake != '1) ? since_wake + 1'b1 : since_wake);
            boot_cnt    <= (boot_cnt != '1) ? boot_cnt + 1'b1 : boot_cnt;
        end
    end

    assert_ready_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !req_ready);
    assert_boot_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        first_now |-> (int'(boot_cnt) >= INIT_CYCLES));
    assert_pair_second_R3: assert property (@(posedge clk) disable iff (!rst_n)
        first_now |=> !(dram_cs_n && !dram_fn));
    assert_cycle_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        first_now |-> (int'(since_first) >= RC_CYCLES));
    assert_ready_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> ((int'(since_first) >= RC_CYCLES - 1) && dram_pd_n));
    assert_pd_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_pd_n |-> (dram_cs_n && !dram_fn && !req_ready));
    assert_pd_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_pd_n) |-> (int'(since_first) >= RC_CYCLES));
    assert_wake_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        first_now |-> (int'(since_wake) >= PDX_CYCLES));
    assert_idle_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_q && dram_cs_n) |-> (!dram_fn && dram_ba == '0 && dram_addr == '0));
endmodule

bind pair_cmd_sequencer pair_cmd_sequencer_chk #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .INIT_CYCLES(INIT_CYCLES),
    .RC_CYCLES(RC_CYCLES), .PDX_CYCLES(PDX_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .init_done(init_done),
    .dram_cs_n(dram_cs_n), .dram_fn(dram_fn), .dram_ba(dram_ba),
    .dram_addr(dram_addr), .dram_pd_n(dram_pd_n)
);

// File: tb/pair_cmd_sequencer_test.sv
`timescale 1ns/1ps
module pair_cmd_sequencer_test;
    localparam int INIT = 200, RC = 5, REFI = 97, PDX = 2;
    localparam logic [14:0] MRV = 15'h0123, EMRV = 15'h0406;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, pd_req = 1'b0;
    logic [1:0] req_op = 2'b00, req_bank = 2'b00;
    logic [14:0] req_row = '0;
    logic [6:0] req_col = '0;
    logic req_ready, init_done, dram_cs_n, dram_fn, dram_pd_n;
    logic [1:0] dram_ba;
    logic [14:0] dram_addr;

    always #2.5 clk = ~clk;

    pair_cmd_sequencer #(.INIT_CYCLES(INIT), .RC_CYCLES(RC), .REFI_CYCLES(REFI),
        .PDX_CYCLES(PDX), .MR_VALUE(MRV), .EMR_VALUE(EMRV)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .pd_req(pd_req), .init_done(init_done), .dram_cs_n(dram_cs_n), .dram_fn(dram_fn),
        .dram_ba(dram_ba), .dram_addr(dram_addr), .dram_pd_n(dram_pd_n));

    int n_checks = 0, n_fail = 0;
    task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor state.
    int cyc = 0, last_first = -1000, last_ref = -1, wake_cyc = -1000, init_cyc = -1;
    int n_boot = 0, n_ref = 0, n_user = 0, n_pd_enter = 0, last_user = -1, prev_user = -1;
    bit e2_valid = 0, acc_prev = 0, prev_pd = 1;
    int e2_code = 0, e2_fields = 0;
    string e2_req = "R3";
    logic [1:0] c_op, c_bank;
    logic [14:0] c_row;
    logic [6:0] c_col;

    function automatic int fields(input logic [1:0] b, input logic [14:0] a);
        return int'({b, a});
    endfunction
    function automatic int code(input logic cs, input logic f);
        return int'({cs, f});
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            cyc = 0; e2_valid = 0; acc_prev = 0; prev_pd = 1;
        end else begin
            cyc++;
            if (e2_valid) begin
                chk(code(dram_cs_n, dram_fn) == e2_code, "R3", code(dram_cs_n, dram_fn), e2_code, "second command code");
                chk(fields(dram_ba, dram_addr) == e2_fields, e2_req, fields(dram_ba, dram_addr), e2_fields, "second command fields");
                e2_valid = 0;
            end else if (!dram_cs_n) begin
                if (last_first >= 0) chk(cyc - last_first >= RC, "R7", cyc - last_first, RC, "first-command spacing");
                chk(dram_pd_n == 1'b1, "R10", int'(dram_pd_n), 1, "command during power-down");
                chk(cyc - wake_cyc >= PDX, "R11", cyc - wake_cyc, PDX, "wake-up gap");
                last_first = cyc;
                if (n_boot < 2) begin
                    chk(cyc >= INIT, "R2", cyc, INIT, "start-up wait");
                    chk(dram_fn && fields(dram_ba, dram_addr) == fields(2'(n_boot), n_boot == 0 ? MRV : EMRV),
                        "R2", fields(dram_ba, dram_addr), fields(2'(n_boot), n_boot == 0 ? MRV : EMRV), "mode pair first");
                    e2_code = code(1'b0, 1'b0); e2_fields = fields(2'(n_boot), n_boot == 0 ? MRV : EMRV); e2_req = "R2";
                    n_boot++;
                end else if (acc_prev) begin
                    prev_user = last_user; last_user = cyc; n_user++;
                    if (c_op[1]) begin
                        chk(dram_fn && fields(dram_ba, dram_addr) == fields(c_bank, c_row), "R6",
                            fields(dram_ba, dram_addr), fields(c_bank, c_row), "mode request first");
                        e2_code = code(1'b0, 1'b0); e2_fields = fields(c_bank, c_row); e2_req = "R6";
                    end else begin
                        chk(dram_fn == !c_op[0] && fields(dram_ba, dram_addr) == fields(c_bank, c_row),
                            c_op[0] ? "R5" : "R4", code(dram_fn, 1'b0), code(!c_op[0], 1'b0), "activate kind/row");
                        e2_code = code(1'b1, 1'b1); e2_fields = fields(c_bank, 15'(c_col)); e2_req = c_op[0] ? "R5" : "R4";
                    end
                end else begin
                    chk(!dram_fn && fields(dram_ba, dram_addr) == 0, "R9", fields(dram_ba, dram_addr), 0, "refresh first");
                    if (last_ref >= 0) begin
                        chk(cyc - last_ref <= REFI + RC + PDX, "R9", cyc - last_ref, REFI + RC + PDX, "refresh interval max");
                        chk(cyc - last_ref >= REFI - RC - PDX, "R9", cyc - last_ref, REFI - RC - PDX, "refresh interval min");
                    end else begin
                        chk(cyc - init_cyc <= REFI + RC + PDX, "R9", cyc - init_cyc, REFI + RC + PDX, "first refresh");
                    end
                    last_ref = cyc; n_ref++;
                    e2_code = code(1'b0, 1'b0); e2_fields = 0; e2_req = "R9";
                end
                e2_valid = 1;
            end else begin
                chk(!dram_fn && fields(dram_ba, dram_addr) == 0, "R12", code(dram_cs_n, dram_fn), code(1'b1, 1'b0), "idle deselect");
                if (acc_prev) chk(0, "R4", 0, 1, "accepted request not issued");
            end
            if (req_ready) begin
                chk(cyc - last_first >= RC - 1 && dram_pd_n, "R8", cyc - last_first, RC - 1, "ready inside gap");
                chk(init_done == 1'b1, "R1", 0, 1, "ready before init_done");
            end
            if (prev_pd && !dram_pd_n) begin
                n_pd_enter++;
                chk(cyc - last_first >= RC, "R10", cyc - last_first, RC, "power-down entry gap");
            end
            if (!dram_pd_n) chk(!req_ready, "R10", int'(req_ready), 0, "ready in power-down");
            if (!prev_pd && dram_pd_n) wake_cyc = cyc;
            if (init_done && init_cyc < 0) begin
                init_cyc = cyc;
                chk(n_boot == 2, "R2", n_boot, 2, "mode pairs before init_done");
            end
            acc_prev = req_valid && req_ready;
            c_op = req_op; c_bank = req_bank; c_row = req_row; c_col = req_col;
            prev_pd = dram_pd_n;
        end
    end

    // Watchdog: an expired run counts as a failure and still prints the summary.
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_checks++; n_fail++;
            $display("FAIL R8 watchdog: actual %0d expected below 150000 cycles", wd);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Present one request at posedge+1 and hold it until taken.
    task automatic issue(input logic [1:0] op, input logic [1:0] bank, input logic [14:0] row, input logic [6:0] col);
        bit taken = 0;
        req_op = op; req_bank = bank; req_row = row; req_col = col; req_valid = 1'b1;
        while (!taken) begin
            @(negedge clk);
            taken = req_ready;
            @(posedge clk); #1;
        end
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        int r, ref0, pd0;
        void'($urandom(32'd7341));
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset values at the pins.
        chk(dram_cs_n && !dram_fn && dram_ba == 0 && dram_addr == 0, "R1", code(dram_cs_n, dram_fn), code(1'b1, 1'b0), "reset command");
        chk(dram_pd_n && !req_ready && !init_done, "R1", int'({dram_pd_n, req_ready, init_done}), 4, "reset flags");
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!req_ready && !init_done && dram_cs_n, "R1", int'({req_ready, init_done}), 0, "first cycle after reset");
        wait (init_done);
        // R8: back-to-back held requests right after a refresh.
        ref0 = n_ref;
        while (n_ref == ref0) @(negedge clk);
        @(posedge clk); #1;
        issue(2'b00, 2'd2, 15'h1abc, 7'h55);
        issue(2'b01, 2'd1, 15'h7001, 7'h7f);
        issue(2'b10, 2'd1, 15'h0007, 7'h00);
        idle(3);
        chk(last_user - prev_user == RC, "R8", last_user - prev_user, RC, "waiting request spacing");
        // R11: power-down held across several refresh intervals.
        ref0 = n_ref; pd0 = n_pd_enter;
        pd_req = 1'b1;
        idle(3 * REFI);
        pd_req = 1'b0;
        idle(4);
        chk(n_ref - ref0 >= 2, "R11", n_ref - ref0, 2, "refreshes while power-down requested");
        chk(n_pd_enter - pd0 >= 2, "R10", n_pd_enter - pd0, 2, "power-down entries");
        chk(dram_pd_n == 1'b1, "R11", int'(dram_pd_n), 1, "exit after request drop");
        // Random mix of requests, idles and short power-down windows.
        for (int i = 0; i < 700; i++) begin
            r = int'($urandom % 100);
            if (r < 7) begin
                pd_req = 1'b1; idle(5 + int'($urandom % 40)); pd_req = 1'b0;
            end else if (r < 75) begin
                issue(2'($urandom), 2'($urandom), 15'($urandom), 7'($urandom));
            end else begin
                idle(int'($urandom % 4) + 1);
            end
        end
        idle(RC + 2);
        chk(n_ref >= (cyc - init_cyc) / (REFI + RC + PDX) - 1, "R9", n_ref, (cyc - init_cyc) / (REFI + RC + PDX) - 1, "refresh count");
        chk(n_user > 300, "R4", n_user, 300, "user pairs issued");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule